// File: doc/BRIEF.md
# Outstanding Miss Tracker for a Non-Blocking Data Cache

This block keeps the bookkeeping for data-cache misses that are still in flight, so the cache can go on serving hits and accept further misses while earlier ones wait for memory. It holds a fixed pool of eight tracking slots. Each slot follows one 128-byte line that has been requested from memory. A slot also keeps a short list of the load identifiers waiting on that line.

Each cycle the cache presents at most one lookup: a byte address, a flag that says whether the tag arrays hit, a load-or-prefetch flag and a load identifier. A hit passes through untouched. A miss takes one of three paths:
- It claims a free slot, and a memory request goes out on the next cycle, tagged with the slot number.
- It joins the slot already tracking the same line, with no second memory request.
- It is held off with a stall.

Memory returns fills tagged with the slot number, in any order. One cycle after a fill, the block reports the line and every waiting load identifier at once, and it frees the slot.

Prefetches are non-binding. They bring in a line but name no destination, so they never take a waiter position.

Top module: `mshr_file`

## Requirements
- R1: After reset all slots are empty and `mem_req_valid` and `done_valid` are low. The first miss after reset receives slot 0.
- R2: A lookup with `lk_hit` high never stalls, issues no memory request and allocates no slot.
- R3: A miss to a line with no slot, accepted without stall, claims the lowest-numbered free slot. On the next cycle `mem_req_valid` is high, with `mem_req_tag` equal to that slot number and `mem_req_line` equal to `lk_addr[31:7]`.
- R4: A miss whose `lk_addr[31:7]` matches a tracked line joins that slot and issues no memory request. A load takes the next waiter position: position 0 is first, up to position 3.
- R5: A prefetch miss (`lk_pf`=1) that claims a slot records no waiter. A prefetch that joins an existing slot never stalls and takes no waiter position.
- R6: A load miss to a tracked line whose slot already holds four waiters raises `lk_stall` in the same cycle. The stalled load changes no state.
- R7: A miss to an untracked line while all eight slots are busy raises `lk_stall` and changes no state.
- R8: A fill with `fill_tag`=k for a busy slot causes, on the next cycle, one cycle of `done_valid` with:
  - `done_tag`=k and `done_line` equal to the tracked line;
  - bit j of `done_mask` set exactly for the waiter positions in use;
  - `done_ids[6j+5:6j]` holding the identifier at position j.
- R9: Fills may arrive in any slot order. A slot freed by a fill can be claimed by a miss in the following cycle.
- R10: A miss to a line whose slot receives a fill in the same cycle raises `lk_stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_hit | input | 1 | Tag arrays hit for this lookup |
| lk_pf | input | 1 | 1 = prefetch, 0 = load |
| lk_addr | input | 32 | Byte address of the access |
| lk_id | input | 6 | Load identifier (ignored for prefetch) |
| lk_stall | output | 1 | Lookup cannot be accepted this cycle |
| mem_req_valid | output | 1 | Memory line request |
| mem_req_tag | output | 3 | Slot number carried by the request |
| mem_req_line | output | 25 | Line address requested |
| fill_valid | input | 1 | Fill response arrives |
| fill_tag | input | 3 | Slot number of the fill |
| done_valid | output | 1 | Completion report for a filled slot |
| done_tag | output | 3 | Slot that completed |
| done_line | output | 25 | Line that was filled |
| done_mask | output | 4 | Waiter positions in use |
| done_ids | output | 24 | Waiting load identifiers, position j at bits 6j+5:6j |

## Verification
The lookup stream mixes several kinds of traffic:
- fresh loads and fresh prefetches;
- loads and prefetches that hit an already tracked line;
- two byte addresses inside one 128-byte line;
- hits on lines that are absent.

This separates allocation from merging and shows that line granularity, not the exact address, decides a match. Filling the waiter list to four and then sending a load and a prefetch to the same line separates the waiter-full stall from the prefetch merge. Filling all eight slots separates the pool-full stall from the hit path.

Fills are returned out of slot order, and each freed slot is reused. A fill is also made to coincide with a lookup of its own line. Together these show that completions carry the right waiters and that the lowest free slot is chosen.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [2:0] {
    LK_NONE  = 3'd0,
    LK_HIT   = 3'd1,
    LK_ALLOC = 3'd2,
    LK_MERGE = 3'd3,
    LK_STALL = 3'd4
  } lk_kind_e;
endpackage

// File: rtl/mshr_entry.sv
module mshr_entry #(
  parameter int LINE_W = 25,
  parameter int ID_W   = 6,
  parameter int WAYS   = 4,
  localparam int CNT_W = $clog2(WAYS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_en,
  input  logic [LINE_W-1:0]    alloc_line,
  input  logic                 alloc_is_ld,
  input  logic                 merge_ld_en,
  input  logic [ID_W-1:0]      req_id,
  input  logic                 fill_en,
  output logic                 valid_o,
  output logic [LINE_W-1:0]    line_o,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [WAYS*ID_W-1:0] ids_o
);
  logic              valid_q;
  logic [LINE_W-1:0] line_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ID_W-1:0]   ids_q [WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
      line_q  <= '0;
      for (int k = 0; k < WAYS; k++) ids_q[k] <= '0;
    end else if (fill_en) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else if (alloc_en) begin
      valid_q  <= 1'b1;
      line_q   <= alloc_line;
      cnt_q    <= alloc_is_ld ? CNT_W'(1) : '0;
      ids_q[0] <= req_id;
    end else if (merge_ld_en) begin
      for (int k = 0; k < WAYS; k++)
        if (k == int'(cnt_q)) ids_q[k] <= req_id;
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign valid_o = valid_q;
  assign line_o  = line_q;
  assign cnt_o   = cnt_q;

  for (genvar g = 0; g < WAYS; g++) begin : g_ids
    assign ids_o[g*ID_W +: ID_W] = ids_q[g];
  end

  // R3
  alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !valid_q);
  // R4
  merge_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    merge_ld_en |-> (valid_q && (int'(cnt_q) < WAYS)));
  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= WAYS);
endmodule

// File: rtl/mshr_lookup.sv
module mshr_lookup #(
  parameter int N      = 8,
  parameter int LINE_W = 25,
  parameter int WAYS   = 4,
  localparam int CNT_W = $clog2(WAYS + 1),
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]        ent_valid,
  input  logic [N*LINE_W-1:0] ent_lines,
  input  logic [N*CNT_W-1:0]  ent_cnts,
  input  logic [LINE_W-1:0]   probe_line,
  output logic [N-1:0]        hit_vec,
  output logic                hit_any,
  output logic [IDX_W-1:0]    hit_idx,
  output logic                hit_full,
  output logic                free_any,
  output logic [IDX_W-1:0]    free_idx
);
  function automatic logic [IDX_W-1:0] lowest_set(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = ent_valid[g] && (ent_lines[g*LINE_W +: LINE_W] == probe_line);
  end

  always_comb begin
    hit_full = 1'b0;
    for (int i = 0; i < N; i++)
      if (hit_vec[i] && (int'(ent_cnts[i*CNT_W +: CNT_W]) == WAYS)) hit_full = 1'b1;
  end

  assign hit_any  = |hit_vec;
  assign hit_idx  = lowest_set(hit_vec);
  assign free_any = ~&ent_valid;
  assign free_idx = lowest_set(~ent_valid);
endmodule

// File: rtl/mshr_file.sv
module mshr_file #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int N          = 8,
  parameter int WAYS       = 4,
  parameter int ID_W       = 6,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int IDX_W  = $clog2(N),
  localparam int CNT_W  = $clog2(WAYS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_valid,
  input  logic                 lk_hit,
  input  logic                 lk_pf,
  input  logic [ADDR_W-1:0]    lk_addr,
  input  logic [ID_W-1:0]      lk_id,
  output logic                 lk_stall,
  output logic                 mem_req_valid,
  output logic [IDX_W-1:0]     mem_req_tag,
  output logic [LINE_W-1:0]    mem_req_line,
  input  logic                 fill_valid,
  input  logic [IDX_W-1:0]     fill_tag,
  output logic                 done_valid,
  output logic [IDX_W-1:0]     done_tag,
  output logic [LINE_W-1:0]    done_line,
  output logic [WAYS-1:0]      done_mask,
  output logic [WAYS*ID_W-1:0] done_ids
);
  import mshr_pkg::*;

  function automatic logic [WAYS-1:0] cnt_mask(input logic [CNT_W-1:0] c);
    logic [WAYS-1:0] m;
    for (int k = 0; k < WAYS; k++) m[k] = (k < int'(c));
    return m;
  endfunction

  logic [N-1:0]           ent_valid;
  logic [N*LINE_W-1:0]    ent_lines;
  logic [N*CNT_W-1:0]     ent_cnts;
  logic [N*WAYS*ID_W-1:0] ent_ids;

  logic [LINE_W-1:0] probe_line;
  logic [N-1:0]      hit_vec;
  logic              hit_any, hit_full, free_any;
  logic [IDX_W-1:0]  hit_idx, free_idx;

  assign probe_line = lk_addr[ADDR_W-1:OFF_W];

  mshr_lookup #(.N(N), .LINE_W(LINE_W), .WAYS(WAYS)) u_lookup (
    .ent_valid (ent_valid),
    .ent_lines (ent_lines),
    .ent_cnts  (ent_cnts),
    .probe_line(probe_line),
    .hit_vec   (hit_vec),
    .hit_any   (hit_any),
    .hit_idx   (hit_idx),
    .hit_full  (hit_full),
    .free_any  (free_any),
    .free_idx  (free_idx)
  );

  // named internal events
  logic     miss_ev, fill_live_ev, collide_ev, alloc_ev, merge_ld_ev;
  lk_kind_e lk_kind;

  assign miss_ev      = lk_valid && !lk_hit;
  assign fill_live_ev = fill_valid && ent_valid[fill_tag];
  assign collide_ev   = miss_ev && fill_valid && hit_any && (hit_idx == fill_tag);

  always_comb begin
    if (!lk_valid)                           lk_kind = LK_NONE;
    else if (lk_hit)                         lk_kind = LK_HIT;
    else if (collide_ev)                     lk_kind = LK_STALL;
    else if (hit_any && !lk_pf && hit_full)  lk_kind = LK_STALL;
    else if (hit_any)                        lk_kind = LK_MERGE;
    else if (!free_any)                      lk_kind = LK_STALL;
    else                                     lk_kind = LK_ALLOC;
  end

  assign lk_stall    = (lk_kind == LK_STALL);
  assign alloc_ev    = (lk_kind == LK_ALLOC);
  assign merge_ld_ev = (lk_kind == LK_MERGE) && !lk_pf;

  for (genvar g = 0; g < N; g++) begin : g_ent
    mshr_entry #(.LINE_W(LINE_W), .ID_W(ID_W), .WAYS(WAYS)) u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_en   (alloc_ev && (free_idx == IDX_W'(g))),
      .alloc_line (probe_line),
      .alloc_is_ld(!lk_pf),
      .merge_ld_en(merge_ld_ev && (hit_idx == IDX_W'(g))),
      .req_id     (lk_id),
      .fill_en    (fill_valid && (fill_tag == IDX_W'(g))),
      .valid_o    (ent_valid[g]),
      .line_o     (ent_lines[g*LINE_W +: LINE_W]),
      .cnt_o      (ent_cnts[g*CNT_W +: CNT_W]),
      .ids_o      (ent_ids[g*WAYS*ID_W +: WAYS*ID_W])
    );
  end

  // fill-side selection
  logic [LINE_W-1:0]    sel_line;
  logic [CNT_W-1:0]     sel_cnt;
  logic [WAYS*ID_W-1:0] sel_ids;

  always_comb begin
    sel_line = '0;
    sel_cnt  = '0;
    sel_ids  = '0;
    for (int i = 0; i < N; i++)
      if (fill_tag == IDX_W'(i)) begin
        sel_line = ent_lines[i*LINE_W +: LINE_W];
        sel_cnt  = ent_cnts[i*CNT_W +: CNT_W];
        sel_ids  = ent_ids[i*WAYS*ID_W +: WAYS*ID_W];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req_valid <= 1'b0;
      mem_req_tag   <= '0;
      mem_req_line  <= '0;
      done_valid    <= 1'b0;
      done_tag      <= '0;
      done_line     <= '0;
      done_mask     <= '0;
      done_ids      <= '0;
    end else begin
      mem_req_valid <= alloc_ev;
      if (alloc_ev) begin
        mem_req_tag  <= free_idx;
        mem_req_line <= probe_line;
      end
      done_valid <= fill_live_ev;
      if (fill_live_ev) begin
        done_tag  <= fill_tag;
        done_line <= sel_line;
        done_mask <= cnt_mask(sel_cnt);
        done_ids  <= sel_ids;
      end
    end
  end

  // R3
  mem_req_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ent_valid[mem_req_tag]);
  // R2
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_hit && !fill_valid) |=> (!mem_req_valid && $stable(ent_valid)));
  // R7
  stall_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_stall && !fill_valid) |=> (!mem_req_valid && $stable(ent_valid)));
  // R8
  done_follows_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(fill_valid));
  // R4
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: tb/sim_mshr_file.sv
module sim_mshr_file;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_hit = 1'b0, lk_pf = 1'b0;
  logic [31:0] lk_addr = '0;
  logic [5:0]  lk_id = '0;
  logic        lk_stall;
  logic        mem_req_valid;
  logic [2:0]  mem_req_tag;
  logic [24:0] mem_req_line;
  logic        fill_valid = 1'b0;
  logic [2:0]  fill_tag = '0;
  logic        done_valid;
  logic [2:0]  done_tag;
  logic [24:0] done_line;
  logic [3:0]  done_mask;
  logic [23:0] done_ids;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  mshr_file u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_pf(lk_pf),
    .lk_addr(lk_addr), .lk_id(lk_id), .lk_stall(lk_stall),
    .mem_req_valid(mem_req_valid), .mem_req_tag(mem_req_tag), .mem_req_line(mem_req_line),
    .fill_valid(fill_valid), .fill_tag(fill_tag),
    .done_valid(done_valid), .done_tag(done_tag), .done_line(done_line),
    .done_mask(done_mask), .done_ids(done_ids)
  );

  // {hit, pf, addr[31:0], id[5:0], exp_stall, exp_req, exp_tag[2:0]}
  localparam int NV = 18;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 1'b0, 32'h0000_1000, 6'd1,  1'b0, 1'b1, 3'd0},  // R3 A
    {1'b0, 1'b0, 32'h0000_2000, 6'd2,  1'b0, 1'b1, 3'd1},  // R3 B
    {1'b0, 1'b0, 32'h0000_107C, 6'd3,  1'b0, 1'b0, 3'd0},  // R4 same line as A
    {1'b1, 1'b0, 32'h0000_3000, 6'd9,  1'b0, 1'b0, 3'd0},  // R2 hit on C
    {1'b0, 1'b1, 32'h0000_3000, 6'd0,  1'b0, 1'b1, 3'd2},  // R5 prefetch C
    {1'b0, 1'b0, 32'h0000_3010, 6'd4,  1'b0, 1'b0, 3'd0},  // R4 load joins C
    {1'b0, 1'b0, 32'h0000_1004, 6'd5,  1'b0, 1'b0, 3'd0},  // R4 A
    {1'b0, 1'b0, 32'h0000_1008, 6'd6,  1'b0, 1'b0, 3'd0},  // R4 A, four waiters
    {1'b0, 1'b0, 32'h0000_1000, 6'd7,  1'b1, 1'b0, 3'd0},  // R6 waiter list full
    {1'b0, 1'b1, 32'h0000_1000, 6'd0,  1'b0, 1'b0, 3'd0},  // R5 prefetch merge
    {1'b0, 1'b0, 32'h0000_4000, 6'd8,  1'b0, 1'b1, 3'd3},
    {1'b0, 1'b0, 32'h0000_5000, 6'd9,  1'b0, 1'b1, 3'd4},
    {1'b0, 1'b0, 32'h0000_6000, 6'd10, 1'b0, 1'b1, 3'd5},
    {1'b0, 1'b0, 32'h0000_7000, 6'd11, 1'b0, 1'b1, 3'd6},
    {1'b0, 1'b0, 32'h0000_8000, 6'd12, 1'b0, 1'b1, 3'd7},
    {1'b0, 1'b0, 32'h0000_9000, 6'd13, 1'b1, 1'b0, 3'd0},  // R7 pool full
    {1'b1, 1'b0, 32'h0000_A000, 6'd14, 1'b0, 1'b0, 3'd0},  // R2 hit while full
    {1'b0, 1'b1, 32'h0000_2040, 6'd0,  1'b0, 1'b0, 3'd0}   // R5 prefetch joins B
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic lookup(input logic h, input logic p, input logic [31:0] a, input logic [5:0] id);
    lk_valid = 1'b1; lk_hit = h; lk_pf = p; lk_addr = a; lk_id = id;
  endtask

  task automatic idle;
    lk_valid = 1'b0; lk_hit = 1'b0; lk_pf = 1'b0; fill_valid = 1'b0;
  endtask

  task automatic check_done(input string req, input logic [2:0] tag, input logic [31:0] addr,
                            input logic [3:0] mask, input logic [23:0] ids);
    chk(req, done_valid, 1);
    chk(req, done_tag, tag);
    chk(req, done_line, addr[31:7]);
    chk(req, done_mask, mask);
    for (int j = 0; j < 4; j++)
      if (mask[j]) chk(req, done_ids[j*6 +: 6], ids[j*6 +: 6]);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 mem_req_valid", mem_req_valid, 0);
    chk("R1 done_valid", done_valid, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [44:0] e;
      e = VEC[v];
      lookup(e[44], e[43], e[42:11], e[10:5]);
      #1;
      chk($sformatf("R2/R3/R4/R5/R6/R7 stall vec %0d", v), lk_stall, e[4]);
      step();
      idle();
      chk($sformatf("R3/R4 req vec %0d", v), mem_req_valid, e[3]);
      if (e[3]) begin
        chk($sformatf("R3 tag vec %0d", v), mem_req_tag, e[2:0]);
        chk($sformatf("R3 line vec %0d", v), mem_req_line, e[42:18]);
      end
    end

    // R8 fill B (tag 1) out of order: one waiter, id 2
    fill_valid = 1'b1; fill_tag = 3'd1;
    step(); idle();
    check_done("R8 fill B", 3'd1, 32'h2000, 4'b0001, {18'd0, 6'd2});
    step();
    chk("R8 done one cycle", done_valid, 0);

    // R9 freed slot 1 reused by I
    lookup(1'b0, 1'b0, 32'h9000, 6'd13);
    #1 chk("R9 no stall after free", lk_stall, 0);
    step(); idle();
    chk("R9 req", mem_req_valid, 1);
    chk("R9 tag", mem_req_tag, 1);

    // R8 fill A (tag 0): four waiters 1,3,5,6
    fill_valid = 1'b1; fill_tag = 3'd0;
    step(); idle();
    check_done("R8 fill A", 3'd0, 32'h1000, 4'b1111, {6'd6, 6'd5, 6'd3, 6'd1});

    // R5 fill C (tag 2): prefetch-allocated, load 4 in position 0
    fill_valid = 1'b1; fill_tag = 3'd2;
    step(); idle();
    check_done("R5 fill C", 3'd2, 32'h3000, 4'b0001, {18'd0, 6'd4});

    // R10 lookup D while slot 3 fills
    fill_valid = 1'b1; fill_tag = 3'd3;
    lookup(1'b0, 1'b0, 32'h4020, 6'd20);
    #1 chk("R10 collide stall", lk_stall, 1);
    step(); idle();
    chk("R10 no req", mem_req_valid, 0);
    check_done("R10 fill D", 3'd3, 32'h4000, 4'b0001, {18'd0, 6'd8});

    // R9 D again: lowest free slot is 0
    lookup(1'b0, 1'b0, 32'h4020, 6'd20);
    step(); idle();
    chk("R9 lowest free", mem_req_tag, 0);
    chk("R9 req D", mem_req_valid, 1);

    // R1 reset mid-run clears the pool
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    chk("R1 after reset req", mem_req_valid, 0);
    lookup(1'b0, 1'b0, 32'h4000, 6'd21);
    #1 chk("R1 no stall after reset", lk_stall, 0);
    step(); idle();
    chk("R1 first tag", mem_req_tag, 0);
    chk("R1 req after reset", mem_req_valid, 1);

    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end
endmodule